// File: doc/BRIEF.md
# Dual-Mode Host Access Port

This block is a slave port through which an external host reads and writes a processor's internal memory. The host sees three registers: a control word, an address pointer and a data window. A static mode input picks one of two host styles. In register-indirect mode, a two-bit select code picks the register, and an address strobe can load the pointer from the host data bus. In direct mode, the host supplies a full memory address on its own address bus, and every strobe is a data-window access at that address.

A transfer is timed by two host data strobes and qualified by chip select. A separate read/not-write input sets its direction. A ready output drops while the memory side is busy and rises again once a read word is on the host data bus or a write has been accepted. In register-indirect mode the DSP side can raise an active-low interrupt to the host, and the host can send a one-cycle interrupt to the DSP through the control word.

The memory side is a valid/ready request channel followed by a read response. The port holds a request with its address, direction and write data unchanged until the memory raises ready, so the memory may stall for any number of cycles. A read response is a single-cycle valid pulse with no back-pressure. The memory may send it only after the read request has been accepted. All host inputs are taken to be synchronous to the port clock.

Top module: `host_access_port`

## Requirements
- R1: After reset, ready is high, the host interrupt output is high (deasserted), no memory request is valid, and the DSP interrupt pulse is low.
- R2: In register-indirect mode (mode_direct low), select code 2'b10 addresses the pointer. A write loads the host data word, zero-extended, into the pointer, and a read returns the pointer's low data-width bits.
- R3: In register-indirect mode, a falling edge of the active-low address strobe loads the host data word, zero-extended, into the pointer.
- R4: In register-indirect mode, select code 2'b01 performs a memory access at the pointer and then increments it by one, with the carry passing into the address bits above the data width. Select code 2'b11 performs the same access with no increment.
- R5: For a data-window read, ready goes low the cycle after the strobe starts. It rises only when the memory's read word is present on host_dout.
- R6: The effective strobe is active when exactly one of ds1_n and ds2_n is low and cs_n is low. A transfer starts on its activation and a write is committed on its release. Both strobes low together, or cs_n high, starts nothing.
- R7: In register-indirect mode, a DSP raise pulse sets the host interrupt flag, which drives host_irq_n low and reads back as bit 1 of the control word. The host clears the flag by writing a control word with bit 1 set. Writing 0 there leaves it set, and a raise wins over a clear in the same cycle.
- R8: In register-indirect mode, a host control write with bit 0 set produces a single-cycle pulse on to_dsp_irq.
- R9: In direct mode, every data access uses host_addr as the memory address. Select code and address strobe have no effect, and no auto-increment takes place.
- R10: In direct mode, host_irq_n stays high whatever the DSP raises, and to_dsp_irq never pulses.
- R11: rdy_oe equals off_n, so ready is driven only while off_n is high.
- R12: A memory request keeps valid, address, direction and write data unchanged until it is accepted with mem_req_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_direct | input | 1 | Static mode: 0 register-indirect, 1 direct address |
| reg_sel | input | 2 | Register select code (indirect mode only) |
| addr_stb_n | input | 1 | Active-low address strobe (indirect mode only) |
| cs_n | input | 1 | Active-low chip select |
| ds1_n | input | 1 | Host data strobe one, active low |
| ds2_n | input | 1 | Host data strobe two, active low |
| rnw | input | 1 | Transfer direction: 1 read, 0 write |
| host_addr | input | AW | Host address bus (direct mode) |
| host_din | input | DW | Data from host |
| host_dout | output | DW | Data to host |
| rdy | output | 1 | Port ready for next transfer |
| rdy_oe | output | 1 | Drive enable for rdy |
| off_n | input | 1 | Active-low output-off control |
| host_irq_n | output | 1 | Active-low interrupt to host |
| dsp_raise_irq | input | 1 | DSP pulse that raises the host interrupt |
| to_dsp_irq | output | 1 | Single-cycle interrupt to the DSP |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_we | output | 1 | Request is a write |
| mem_req_addr | output | AW | Request address |
| mem_req_wdata | output | DW | Request write data |
| mem_rsp_valid | input | 1 | Read response valid (single cycle) |
| mem_rsp_rdata | input | DW | Read response word |

## Verification
The bench builds the port with its default widths: an 18-bit address and a 16-bit data word. With these widths the pointer is wider than anything the host can load in register-indirect mode. Auto-increment from 0xFFFF therefore has to carry into address bit 16, and the bench checks that carry at the memory request. Only direct mode can reach the top address bits directly, and the bench drives random 18-bit addresses there. A memory model with random stall and response latency exercises request hold and the timing of ready.

// File: rtl/hap_pkg.sv
package hap_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL     = 2'b00,
    SEL_DATA_INC = 2'b01,
    SEL_ADDR     = 2'b10,
    SEL_DATA     = 2'b11
  } sel_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_WR_REQ
  } st_e;

  localparam int CTRL_DSPIRQ_BIT  = 0;
  localparam int CTRL_HOSTIRQ_BIT = 1;
endpackage

// File: rtl/hap_strobe_detect.sv
module hap_strobe_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_direct,
  input  logic cs_n,
  input  logic ds1_n,
  input  logic ds2_n,
  input  logic addr_stb_n,
  output logic xfer_start,
  output logic xfer_end,
  output logic as_latch
);
  logic stb_n_c;
  logic stb_d;
  logic as_d;

  // active (low) only when exactly one data strobe is low and chip select is low
  assign stb_n_c = cs_n | (ds1_n ~^ ds2_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_d <= 1'b1;
      as_d  <= 1'b1;
    end else begin
      stb_d <= stb_n_c;
      as_d  <= addr_stb_n;
    end
  end

  assign xfer_start = stb_d & ~stb_n_c;
  assign xfer_end   = ~stb_d & stb_n_c;
  assign as_latch   = ~mode_direct & as_d & ~addr_stb_n;
endmodule

// File: rtl/hap_regs.sv
module hap_regs
  import hap_pkg::*;
#(
  parameter int AW = 18,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_direct,
  input  logic          as_latch,
  input  logic          wr_ctrl,
  input  logic          wr_addr,
  input  logic          addr_inc,
  input  logic [DW-1:0] host_din,
  input  logic          dsp_raise_irq,
  output logic [AW-1:0] addr_reg,
  output logic [DW-1:0] ctrl_view,
  output logic          host_irq_n,
  output logic          to_dsp_irq
);
  logic hint;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_reg   <= '0;
      hint       <= 1'b0;
      to_dsp_irq <= 1'b0;
    end else begin
      if (as_latch || wr_addr)
        addr_reg <= AW'(host_din);
      else if (addr_inc)
        addr_reg <= addr_reg + AW'(1);

      if (dsp_raise_irq && !mode_direct)
        hint <= 1'b1;
      else if (wr_ctrl && host_din[CTRL_HOSTIRQ_BIT])
        hint <= 1'b0;

      to_dsp_irq <= wr_ctrl && host_din[CTRL_DSPIRQ_BIT] && !mode_direct;
    end
  end

  always_comb begin
    ctrl_view = '0;
    ctrl_view[CTRL_HOSTIRQ_BIT] = hint;
  end

  assign host_irq_n = !(hint && !mode_direct);

  p_hint_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && host_din[CTRL_HOSTIRQ_BIT] && !dsp_raise_irq) |=> host_irq_n);

  p_dsp_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    to_dsp_irq |=> !to_dsp_irq);

  p_ptr_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_inc && !as_latch && !wr_addr) |=> addr_reg == $past(addr_reg) + AW'(1));
endmodule

// File: rtl/hap_mem_seq.sv
module hap_mem_seq
  import hap_pkg::*;
#(
  parameter int AW = 18,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_direct,
  input  logic          xfer_start,
  input  logic          xfer_end,
  input  logic          rnw,
  input  logic [1:0]    reg_sel,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_din,
  input  logic [AW-1:0] addr_reg,
  input  logic [DW-1:0] ctrl_view,
  output logic          wr_ctrl,
  output logic          wr_addr,
  output logic          addr_inc,
  output logic          rdy,
  output logic [DW-1:0] host_dout,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_we,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_rdata
);
  st_e  st;
  sel_e sel_now, sel_q;
  logic armed, rnw_q, inc_q;
  logic is_data_now, is_data_q, idle, accept, commit_wr, rd_done, wr_done;

  assign sel_now     = mode_direct ? SEL_DATA : sel_e'(reg_sel);
  assign is_data_now = (sel_now == SEL_DATA_INC) || (sel_now == SEL_DATA);
  assign is_data_q   = (sel_q == SEL_DATA_INC) || (sel_q == SEL_DATA);
  assign idle        = (st == ST_IDLE);
  assign accept      = idle && xfer_start;
  assign commit_wr   = idle && xfer_end && armed && !rnw_q;
  assign rd_done     = (st == ST_RD_WAIT) && mem_rsp_valid;
  assign wr_done     = (st == ST_WR_REQ) && mem_req_ready;

  assign wr_ctrl       = commit_wr && (sel_q == SEL_CTRL);
  assign wr_addr       = commit_wr && (sel_q == SEL_ADDR);
  assign addr_inc      = inc_q && (rd_done || wr_done);
  assign mem_req_valid = (st == ST_RD_REQ) || (st == ST_WR_REQ);
  assign mem_req_we    = (st == ST_WR_REQ);
  assign rdy           = idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st            <= ST_IDLE;
      sel_q         <= SEL_CTRL;
      armed         <= 1'b0;
      rnw_q         <= 1'b0;
      inc_q         <= 1'b0;
      mem_req_addr  <= '0;
      mem_req_wdata <= '0;
      host_dout     <= '0;
    end else begin
      if (xfer_end) armed <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (accept) begin
            armed        <= 1'b1;
            rnw_q        <= rnw;
            sel_q        <= sel_now;
            inc_q        <= (sel_now == SEL_DATA_INC);
            mem_req_addr <= mode_direct ? host_addr : addr_reg;
            if (rnw) begin
              if (is_data_now)               st        <= ST_RD_REQ;
              else if (sel_now == SEL_CTRL)  host_dout <= ctrl_view;
              else                           host_dout <= DW'(addr_reg);
            end
          end else if (commit_wr && is_data_q) begin
            mem_req_wdata <= host_din;
            st            <= ST_WR_REQ;
          end
        end
        ST_RD_REQ:  if (mem_req_ready) st <= ST_RD_WAIT;
        ST_RD_WAIT: if (mem_rsp_valid) begin
          host_dout <= mem_rsp_rdata;
          st        <= ST_IDLE;
        end
        ST_WR_REQ:  if (mem_req_ready) st <= ST_IDLE;
        default:    st <= ST_IDLE;
      endcase
    end
  end

  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we) && $stable(mem_req_wdata)));

  p_read_return_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> (rdy && host_dout == $past(mem_rsp_rdata)));
endmodule

// File: rtl/host_access_port.sv
module host_access_port #(
  parameter int AW = 18,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_direct,
  input  logic [1:0]    reg_sel,
  input  logic          addr_stb_n,
  input  logic          cs_n,
  input  logic          ds1_n,
  input  logic          ds2_n,
  input  logic          rnw,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_din,
  output logic [DW-1:0] host_dout,
  output logic          rdy,
  output logic          rdy_oe,
  input  logic          off_n,
  output logic          host_irq_n,
  input  logic          dsp_raise_irq,
  output logic          to_dsp_irq,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_we,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_rdata
);
  logic          xfer_start, xfer_end, as_latch;
  logic          wr_ctrl, wr_addr, addr_inc;
  logic [AW-1:0] addr_reg;
  logic [DW-1:0] ctrl_view;

  assign rdy_oe = off_n;

  hap_strobe_detect u_strobe (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_direct(mode_direct),
    .cs_n       (cs_n),
    .ds1_n      (ds1_n),
    .ds2_n      (ds2_n),
    .addr_stb_n (addr_stb_n),
    .xfer_start (xfer_start),
    .xfer_end   (xfer_end),
    .as_latch   (as_latch)
  );

  hap_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_direct  (mode_direct),
    .as_latch     (as_latch),
    .wr_ctrl      (wr_ctrl),
    .wr_addr      (wr_addr),
    .addr_inc     (addr_inc),
    .host_din     (host_din),
    .dsp_raise_irq(dsp_raise_irq),
    .addr_reg     (addr_reg),
    .ctrl_view    (ctrl_view),
    .host_irq_n   (host_irq_n),
    .to_dsp_irq   (to_dsp_irq)
  );

  hap_mem_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_direct  (mode_direct),
    .xfer_start   (xfer_start),
    .xfer_end     (xfer_end),
    .rnw          (rnw),
    .reg_sel      (reg_sel),
    .host_addr    (host_addr),
    .host_din     (host_din),
    .addr_reg     (addr_reg),
    .ctrl_view    (ctrl_view),
    .wr_ctrl      (wr_ctrl),
    .wr_addr      (wr_addr),
    .addr_inc     (addr_inc),
    .rdy          (rdy),
    .host_dout    (host_dout),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_req_we   (mem_req_we),
    .mem_req_addr (mem_req_addr),
    .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata)
  );
endmodule

// File: tb/host_access_port_bench.sv
module host_access_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 18;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode_direct = 1'b0;
  logic [1:0]    reg_sel = 2'b00;
  logic          addr_stb_n = 1'b1;
  logic          cs_n = 1'b1, ds1_n = 1'b1, ds2_n = 1'b1, rnw = 1'b1;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] host_din = '0;
  logic [DW-1:0] host_dout;
  logic          rdy, rdy_oe, host_irq_n, to_dsp_irq;
  logic          off_n = 1'b1;
  logic          dsp_raise_irq = 1'b0;
  logic          mem_req_valid, mem_req_we;
  logic          mem_req_ready = 1'b0;
  logic [AW-1:0] mem_req_addr;
  logic [DW-1:0] mem_req_wdata;
  logic          mem_rsp_valid = 1'b0;
  logic [DW-1:0] mem_rsp_rdata = '0;

  int n_chk = 0, n_bad = 0;
  int wr_cnt = 0, dsp_pulses = 0;
  logic [AW-1:0] wr_addr_l = '0, rd_addr = '0;
  logic [DW-1:0] wr_data_l = '0;
  bit  rd_pend = 0;
  int  rd_wait = 0, stall = 0;
  bit  finished = 0;

  host_access_port u_host_access_port (.*);

  initial forever #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
    logic [AW-1:0] m;
    m = a * AW'(7);
    return DW'(m) ^ 16'h3C5A;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: random stall on requests, random latency on read responses
  always @(negedge clk) begin
    mem_rsp_valid = 1'b0;
    mem_req_ready = 1'b0;
    if (!rst_n) begin
      rd_pend = 0;
      stall = 0;
    end else begin
      if (rd_pend) begin
        if (rd_wait == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_rdata = mem_word(rd_addr);
          rd_pend = 0;
        end else rd_wait--;
      end else if (mem_req_valid) begin
        if ($urandom_range(0, 2) == 0 || stall >= 3) begin
          mem_req_ready = 1'b1;
          stall = 0;
          if (mem_req_we) begin
            wr_cnt++;
            wr_addr_l = mem_req_addr;
            wr_data_l = mem_req_wdata;
          end else begin
            rd_pend = 1;
            rd_addr = mem_req_addr;
            rd_wait = $urandom_range(0, 3);
          end
        end else stall++;
      end
    end
  end

  always @(negedge clk) if (rst_n && to_dsp_irq) dsp_pulses++;

  task automatic do_reset(input logic direct);
    @(negedge clk);
    rst_n = 1'b0; mode_direct = direct;
    cs_n = 1'b1; ds1_n = 1'b1; ds2_n = 1'b1; addr_stb_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic host_wr(input logic [1:0] sel, input logic [DW-1:0] d);
    @(negedge clk);
    cs_n = 1'b0; rnw = 1'b0; reg_sel = sel; host_din = d;
    if ($urandom_range(0, 1) == 1) ds2_n = 1'b0; else ds1_n = 1'b0;
    @(negedge clk);
    ds1_n = 1'b1; ds2_n = 1'b1;
    @(negedge clk);
    while (!rdy) @(negedge clk);
  endtask

  task automatic host_rd(input logic [1:0] sel, output logic [DW-1:0] d, output bit busy);
    @(negedge clk);
    cs_n = 1'b0; rnw = 1'b1; reg_sel = sel;
    if ($urandom_range(0, 1) == 1) ds2_n = 1'b0; else ds1_n = 1'b0;
    @(negedge clk);
    busy = !rdy;
    while (!rdy) @(negedge clk);
    d = host_dout;
    ds1_n = 1'b1; ds2_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic addr_strobe(input logic [DW-1:0] a);
    @(negedge clk);
    host_din = a; addr_stb_n = 1'b0;
    @(negedge clk);
    addr_stb_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic dsp_raise();
    @(negedge clk);
    dsp_raise_irq = 1'b1;
    @(negedge clk);
    dsp_raise_irq = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [DW-1:0] d;
    logic [AW-1:0] exp_addr;
    bit busy;
    int w0, p0;
    void'($urandom(32'h1F2E3D4C));

    // ---------- register-indirect mode ----------
    do_reset(1'b0);
    chk("R1 rdy", rdy, 1);
    chk("R1 host_irq_n", host_irq_n, 1);
    chk("R1 req_valid", mem_req_valid, 0);
    chk("R1 to_dsp_irq", to_dsp_irq, 0);

    off_n = 1'b0; #1; chk("R11 oe off", rdy_oe, 0);
    off_n = 1'b1; #1; chk("R11 oe on", rdy_oe, 1);

    host_wr(2'b10, 16'h1234);
    host_rd(2'b10, d, busy); chk("R2 ptr readback", d, 16'h1234);

    host_wr(2'b01, 16'hBEEF);
    chk("R4 write addr", wr_addr_l, 18'h01234);
    chk("R4 write data", wr_data_l, 16'hBEEF);
    host_rd(2'b10, d, busy); chk("R4 inc after write", d, 16'h1235);
    host_rd(2'b11, d, busy);
    chk("R5 read word", d, mem_word(18'h01235));
    chk("R5 ready dropped", busy, 1);
    host_rd(2'b10, d, busy); chk("R4 no inc on 11", d, 16'h1235);
    host_rd(2'b01, d, busy); chk("R5 read inc word", d, mem_word(18'h01235));
    host_rd(2'b10, d, busy); chk("R4 inc after read", d, 16'h1236);

    addr_strobe(16'h00A0);
    host_rd(2'b10, d, busy); chk("R3 strobe load", d, 16'h00A0);

    host_wr(2'b10, 16'hFFFF);
    host_wr(2'b01, 16'h1111); chk("R4 pre-carry addr", wr_addr_l, 18'h0FFFF);
    host_wr(2'b11, 16'h2222); chk("R4 carry into bit16", wr_addr_l, 18'h10000);

    // strobe qualification
    host_wr(2'b10, 16'h0040);
    w0 = wr_cnt;
    @(negedge clk); cs_n = 1'b1; rnw = 1'b0; reg_sel = 2'b10; host_din = 16'h0999; ds1_n = 1'b0;
    @(negedge clk); ds1_n = 1'b1;
    @(negedge clk); cs_n = 1'b0; ds1_n = 1'b0; ds2_n = 1'b0;
    @(negedge clk); ds1_n = 1'b1; ds2_n = 1'b1;
    repeat (3) @(negedge clk);
    host_rd(2'b10, d, busy); chk("R6 no false transfer", d, 16'h0040);
    chk("R6 no mem write", wr_cnt, w0);

    // host interrupt
    dsp_raise();
    chk("R7 irq asserted", host_irq_n, 0);
    host_rd(2'b00, d, busy); chk("R7 ctrl bit1", d, 16'h0002);
    host_wr(2'b00, 16'h0000); chk("R7 write 0 keeps", host_irq_n, 0);
    host_wr(2'b00, 16'h0002); chk("R7 write 1 clears", host_irq_n, 1);

    p0 = dsp_pulses;
    host_wr(2'b00, 16'h0001);
    @(negedge clk);
    chk("R8 dsp pulse count", dsp_pulses, p0 + 1);

    // constrained random mix in indirect mode
    host_wr(2'b10, 16'h0100);
    exp_addr = 18'h00100;
    for (int i = 0; i < 40; i++) begin
      int op;
      logic [DW-1:0] v;
      op = $urandom_range(0, 3);
      v = DW'($urandom);
      case (op)
        0: begin
          logic [1:0] s;
          s = ($urandom_range(0, 1) == 1) ? 2'b01 : 2'b11;
          host_wr(s, v);
          chk("R4 rand write addr", wr_addr_l, exp_addr);
          chk("R4 rand write data", wr_data_l, v);
          if (s == 2'b01) exp_addr = exp_addr + 1;
        end
        1: begin
          logic [1:0] s;
          s = ($urandom_range(0, 1) == 1) ? 2'b01 : 2'b11;
          host_rd(s, d, busy);
          chk("R5 rand read", d, mem_word(exp_addr));
          if (s == 2'b01) exp_addr = exp_addr + 1;
        end
        2: begin host_wr(2'b10, v); exp_addr = AW'(v); end
        default: begin addr_strobe(v); exp_addr = AW'(v); end
      endcase
    end

    // ---------- direct mode ----------
    do_reset(1'b1);
    host_addr = 18'h2ABCD;
    host_wr(2'b10, 16'h7777);
    chk("R9 direct write addr", wr_addr_l, 18'h2ABCD);
    chk("R9 direct write data", wr_data_l, 16'h7777);
    addr_strobe(16'h0005);
    host_addr = 18'h31000;
    host_wr(2'b01, 16'h5A5A);
    chk("R9 strobe ignored", wr_addr_l, 18'h31000);
    host_wr(2'b01, 16'h5A5B);
    chk("R9 no increment", wr_addr_l, 18'h31000);
    for (int i = 0; i < 16; i++) begin
      logic [1:0] s;
      s = 2'($urandom);
      host_addr = AW'($urandom);
      if ($urandom_range(0, 1) == 1) addr_strobe(DW'($urandom));
      host_rd(s, d, busy);
      chk("R9 rand direct read", d, mem_word(host_addr));
    end

    dsp_raise();
    chk("R10 irq stays high", host_irq_n, 1);
    p0 = dsp_pulses;
    host_wr(2'b00, 16'h0003);
    @(negedge clk);
    chk("R10 no dsp pulse", dsp_pulses, p0);
    chk("R10 irq still high", host_irq_n, 1);

    finish_run();
  end
endmodule